// File: doc/BRIEF.md
# DMA Channel Interrupt Pending and Mask Unit

This unit collects interrupt events from a bank of DMA task channels. It holds them in a pending register. A mask register, set by software, decides which of them may raise a request. A one-cycle pulse on a channel's event line latches that channel's pending bit. Software clears pending bits by writing ones to the pending register. Software sets the mask register with a plain write. Channel n always maps to bit n, counted from the least significant bit. A mask bit of 1 blocks the channel, and a mask bit of 0 lets it through.

The unit drives one combined request. This request feeds a single source slot of a cascaded interrupt encoder. The request is high whenever any pending bit is unmasked. Alongside the request, the unit gives the number of the lowest unmasked pending channel with a valid flag, so the encoder does not have to search the register itself. The register port is a plain control port with a write strobe, a one-bit register select and a read path that is valid in the same cycle. There is no stream traffic, so there is no back-pressure to handle. The read port never stalls and a write is always taken in the cycle it is presented.

Top module: `dma_irq_unit`

## Requirements
- R1: After reset the pending register reads all zeros, the mask register reads all ones, and `cascade_req_o`, `first_valid_o` and `first_idx_o` are all 0.
- R2: A 1 on `chan_evt_i[n]` at a clock edge sets pending bit n. Bit n is counted from the least significant bit. The bit reads back as 1 from select 0 (pending) from the next cycle on.
- R3: A write to select 0 clears each pending bit whose write-data bit is 1. Pending bits whose write-data bit is 0 keep their value.
- R4: When an event and a clearing write hit the same pending bit at the same edge, the bit ends up set.
- R5: A write to select 1 (mask) loads the write data into the mask register. The mask register reads back from select 1 from the next cycle on.
- R6: `cascade_req_o` is 1 exactly when some bit is 1 in pending and 0 in mask. A mask bit of 1 disables its channel.
- R7: `first_valid_o` is 1 when some pending bit is unmasked. In that case `first_idx_o` gives the lowest-numbered such channel. Otherwise `first_idx_o` is 0.
- R8: Events on masked channels still set their pending bits. Such a bit raises a request as soon as its mask bit is cleared.
- R9: `reg_rdata_o` shows the register picked by `reg_addr_i` in the same cycle, with no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_evt_i | input | NUM_CH | Per-channel event pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 pending, 1 mask |
| reg_wdata_i | input | NUM_CH | Write data |
| reg_rdata_o | output | NUM_CH | Read data of the selected register |
| cascade_req_o | output | 1 | Combined request to the cascade encoder |
| first_valid_o | output | 1 | The reported index is valid |
| first_idx_o | output | IDX_W | Lowest unmasked pending channel |

## Verification
Event pulses, clearing writes and mask writes act at the clock edge where they are presented. Their effect on the read data, the request and the index is therefore due exactly one cycle later. Read data also follows the register select within the same cycle. The bench drives inputs just after the rising edge. A behavioural model updates at that edge, and the bench compares all outputs with it on the falling edge. Every comparison therefore sees the state one edge after the stimulus, with the select already settled. Directed steps sample at those same falling edges to check the collision, masked-event and no-pending cases.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned DEF_NUM_CH = 32;

  typedef enum logic {
    SEL_PEND = 1'b0,
    SEL_MASK = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/dma_irq_pend_reg.sv
module dma_irq_pend_reg #(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] pend_o
);
  for (genvar b = 0; b < NUM_CH; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_o[b] <= 1'b0;
      else if (set_i[b]) pend_o[b] <= 1'b1;
      else if (clr_i[b]) pend_o[b] <= 1'b0;
    end
  end

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));

  // R3
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((pend_o & $past(clr_i) & ~$past(set_i)) == '0));
endmodule

// File: rtl/dma_irq_mask_reg.sv
module dma_irq_mask_reg #(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_o <= '1;
    else if (we_i) mask_o <= wdata_i;
  end

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (mask_o == $past(wdata_i)));

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(mask_o));
endmodule

// File: rtl/dma_irq_ffs.sv
module dma_irq_ffs #(
  parameter int unsigned NUM_CH = 32,
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] vec_i,
  output logic              valid_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1);

  always_comb begin
    idx_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign valid_o = |vec_i;

  // R7
  lowest_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (vec_i[idx_o] && ((vec_i & ((ONE << idx_o) - ONE)) == '0)));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (idx_o == '0));
endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chan_evt_i,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [NUM_CH-1:0] reg_wdata_i,
  output logic [NUM_CH-1:0] reg_rdata_o,
  output logic              cascade_req_o,
  output logic              first_valid_o,
  output logic [IDX_W-1:0]  first_idx_o
);
  logic [NUM_CH-1:0] pend_q, mask_q, clr_vec, live_vec;
  logic              pend_wr, mask_wr;

  assign pend_wr = reg_we_i && (reg_sel_e'(reg_addr_i) == SEL_PEND);
  assign mask_wr = reg_we_i && (reg_sel_e'(reg_addr_i) == SEL_MASK);
  assign clr_vec = pend_wr ? reg_wdata_i : '0;

  dma_irq_pend_reg #(.NUM_CH(NUM_CH)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(chan_evt_i), .clr_i(clr_vec), .pend_o(pend_q)
  );

  dma_irq_mask_reg #(.NUM_CH(NUM_CH)) u_mask (
    .clk(clk), .rst_n(rst_n), .we_i(mask_wr), .wdata_i(reg_wdata_i), .mask_o(mask_q)
  );

  assign live_vec = pend_q & ~mask_q;

  dma_irq_ffs #(.NUM_CH(NUM_CH)) u_ffs (
    .clk(clk), .rst_n(rst_n), .vec_i(live_vec),
    .valid_o(first_valid_o), .idx_o(first_idx_o)
  );

  assign cascade_req_o = |live_vec;
  assign reg_rdata_o   = (reg_sel_e'(reg_addr_i) == SEL_MASK) ? mask_q : pend_q;

  // R6
  index_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_valid_o |-> (pend_q[first_idx_o] && !mask_q[first_idx_o] && cascade_req_o));

  // R8
  masked_evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_evt_i & mask_q) != '0 |=> ((pend_q & $past(chan_evt_i & mask_q)) != '0));
endmodule

// File: tb/dma_irq_unit_tb.sv
`timescale 1ns/1ps
module dma_irq_unit_tb;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  evt = '0;
  logic          we = 1'b0;
  logic          addr = 1'b0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic          req, fvalid;
  logic [4:0]    fidx;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [N-1:0] m_pend, m_mask;

  always #2 clk = ~clk;

  dma_irq_unit #(.NUM_CH(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .chan_evt_i(evt), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cascade_req_o(req),
    .first_valid_o(fvalid), .first_idx_o(fidx)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend <= '0;
      m_mask <= '1;
    end else begin
      logic [N-1:0] np;
      np = m_pend;
      for (int i = 0; i < N; i++) begin
        if (evt[i]) np[i] = 1'b1;
        else if (we && addr == 1'b0 && wdata[i]) np[i] = 1'b0;
      end
      m_pend <= np;
      if (we && addr == 1'b1) m_mask <= wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [N-1:0] live;
      int first;
      live = m_pend & ~m_mask;
      first = -1;
      for (int i = N - 1; i >= 0; i--) if (live[i]) first = i;
      chk(rdata === (addr ? m_mask : m_pend), "R9 rdata", rdata, addr ? m_mask : m_pend);
      chk(req === (live != 0), "R6 cascade_req", 32'(req), 32'(live != 0));
      chk(fvalid === (first >= 0), "R7 first_valid", 32'(fvalid), 32'(first >= 0));
      chk(fidx === ((first >= 0) ? 5'(first) : 5'd0), "R7 first_idx", 32'(fidx),
          (first >= 0) ? 32'(first) : 32'd0);
    end
  end

  task automatic drive(input logic [N-1:0] e, input logic w, input logic a, input logic [N-1:0] d);
    @(posedge clk); #1;
    evt = e; we = w; addr = a; wdata = d;
  endtask

  task automatic idle_sel(input logic a);
    drive('0, 1'b0, a, '0);
  endtask

  task automatic look(input logic a);
    idle_sel(a);
    @(negedge clk);
  endtask

  initial begin
    #20000;
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(rdata === 32'h0, "R1 pend reset", rdata, 32'h0);
    chk(req === 1'b0 && fvalid === 1'b0 && fidx === 5'd0, "R1 outputs reset",
        {req, fvalid, fidx}, 32'h0);
    look(1'b1);
    chk(rdata === 32'hffff_ffff, "R1 mask reset", rdata, 32'hffff_ffff);

    // R8: event on masked channel latches
    drive(32'h20, 1'b0, 1'b0, '0);
    look(1'b0);
    chk(rdata === 32'h20, "R8 masked event latched", rdata, 32'h20);
    chk(req === 1'b0, "R8 no request while masked", 32'(req), 32'h0);

    // R5 unmask all
    drive('0, 1'b1, 1'b1, 32'h0);
    look(1'b1);
    chk(rdata === 32'h0, "R5 mask readback", rdata, 32'h0);
    chk(req === 1'b1 && fidx === 5'd5, "R8 request after unmask", 32'(fidx), 32'd5);

    // R2 events 3 and 31
    drive(32'h8000_0008, 1'b0, 1'b0, '0);
    look(1'b0);
    chk(rdata === 32'h8000_0028, "R2 events set bits", rdata, 32'h8000_0028);
    chk(fidx === 5'd3, "R7 lowest channel", 32'(fidx), 32'd3);

    // R3 clear bit 3 only
    drive('0, 1'b1, 1'b0, 32'h0000_0008);
    look(1'b0);
    chk(rdata === 32'h8000_0020, "R3 write-one clears", rdata, 32'h8000_0020);
    drive('0, 1'b1, 1'b0, 32'h0);
    look(1'b0);
    chk(rdata === 32'h8000_0020, "R3 write-zero keeps", rdata, 32'h8000_0020);

    // R4 collision on bit 5
    drive(32'h20, 1'b1, 1'b0, 32'h20);
    look(1'b0);
    chk(rdata[5] === 1'b1, "R4 event beats clear", 32'(rdata[5]), 32'h1);

    // R6 masking
    drive('0, 1'b1, 1'b1, 32'h20);
    look(1'b0);
    chk(fidx === 5'd31 && req === 1'b1, "R6 masked bit skipped", 32'(fidx), 32'd31);
    drive('0, 1'b1, 1'b1, 32'h8000_0020);
    look(1'b0);
    chk(req === 1'b0 && fvalid === 1'b0 && fidx === 5'd0, "R7 none unmasked",
        {req, fvalid, fidx}, 32'h0);

    // mixed traffic
    lfsr = 32'hace1_2345;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive((lfsr[3:0] == 0) ? (32'h1 << lfsr[8:4]) : '0, lfsr[11:10] == 2'b00,
            lfsr[12], {lfsr[15:0], lfsr[31:16]} & {32{lfsr[13]}} | (32'h1 << lfsr[20:16]));
    end
    idle_sel(1'b0);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule